// File: doc/BRIEF.md
# Sequence Stimulus Source and Expected-Value Checker

This block pairs two small synthesizable test units that run on one clock and one synchronous, active-high reset. The source side plays a constant list of samples onto its output, one element per clock cycle, starting with the first element while reset is held. When it reaches the end of the list it stays on the last element for as long as the block runs. The list is an arithmetic ramp set by three parameters (first value, increment, length), computed at elaboration time.

The checker side holds its own constant list of expected samples, built the same way from its own parameters. On every cycle out of reset it compares the observed input against the expected element for that cycle. It flags a miscompare in the same cycle and presents the cycle number and the expected value, so the surrounding harness can log all three. After the last expected element has been compared, a done flag rises and stays high. Comparison continues against the final element. A sticky error flag records that at least one miscompare has happened since reset. A separate data path runs through the checker untouched, so the checker can sit in line with a signal without changing it.

Both sides advance every cycle and take no back-pressure: there is no valid/ready handshake. A harness that must pause either list holds the block in reset.

Top module: `seq_stim_check`

## Requirements
- R1: In the k-th cycle after reset is released (k = 0 is the cycle in which reset is first low at the rising edge), `src_data` equals SRC_BASE + k*SRC_STEP, truncated to W bits, for k < SRC_LEN.
- R2: For k >= SRC_LEN - 1, `src_data` holds the last list element, SRC_BASE + (SRC_LEN-1)*SRC_STEP, indefinitely.
- R3: Out of reset, `chk_miscompare` is high in cycle k exactly when `chk_obs` differs from the expected value for that cycle, and `chk_expect` shows that expected value, CHK_BASE + min(k, CHK_LEN-1)*CHK_STEP truncated to W bits.
- R4: `chk_cycle` equals k, the number of cycles since reset was released, and saturates at its all-ones value.
- R5: `chk_done` is low for cycles 0 to CHK_LEN-1, and high from cycle CHK_LEN onward until the next reset.
- R6: From cycle CHK_LEN - 1 onward, the checker keeps comparing against the final expected element.
- R7: `chk_thru_out` always equals `chk_thru_in` in the same cycle, including during reset.
- R8: While reset is high at a rising edge, both list positions return to element 0. During reset `src_data` shows element 0, `chk_cycle` is 0, `chk_done` and `chk_err` are low, and `chk_miscompare` stays low whatever `chk_obs` carries.
- R9: `chk_err` rises in the cycle after the first miscompare and stays high until reset.
- R10: Each list position counter stops at its last position and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous reset, active high |
| src_data | output | W | Current source list element |
| chk_obs | input | W | Observed value to be compared |
| chk_thru_in | input | W | Value carried through the checker |
| chk_thru_out | output | W | Same value, unchanged |
| chk_expect | output | W | Expected value for this cycle |
| chk_miscompare | output | 1 | Observed differs from expected this cycle |
| chk_cycle | output | CYC_W | Cycles since reset release, saturating |
| chk_err | output | 1 | Sticky: some miscompare since reset |
| chk_done | output | 1 | All expected elements compared |

## Verification
The bench uses the default parameters: an 8-bit ramp of 11 odd values from 1 to 21 on the source, and a 10-entry ramp from 0 to 9 on the checker. The source list is longer than the checker list, so one run covers the checker's done edge, its comparisons past the end, and the source's hold on its last value. Miscompares are injected before and after the checker's last element. A reset in the middle of a run shows both lists restarting, the sticky flag clearing, and a clean second pass leaving it low.

// File: rtl/sp_pkg.sv
package sp_pkg;

  // Element i of an arithmetic ramp list, before truncation to the data width.
  function automatic int ramp_elem(input int base, input int step, input int i);
    return base + i * step;
  endfunction

  // Index width for a list of len entries (at least one bit).
  function automatic int idx_width(input int len);
    return (len > 1) ? $clog2(len) : 1;
  endfunction

endpackage

// File: rtl/sp_idx_ctr.sv
module sp_idx_ctr #(
  parameter int LEN = 8,
  localparam int IW = sp_pkg::idx_width(LEN)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [IW-1:0] idx,
  output logic          at_last
);
  localparam logic [IW-1:0] LAST = IW'(LEN - 1);

  assign at_last = (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst)           idx <= '0;
    else if (!at_last) idx <= idx + 1'b1;
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST);                                                   // R10
  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    !at_last |=> idx == $past(idx) + 1'b1);                         // R1
  AST_IDX_PARKED: assert property (@(posedge clk) disable iff (rst)
    at_last |=> at_last);                                           // R10

endmodule

// File: rtl/sp_stim_gen.sv
module sp_stim_gen #(
  parameter int W    = 8,
  parameter int LEN  = 11,
  parameter int BASE = 1,
  parameter int STEP = 2
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] data
);
  localparam int IW = sp_pkg::idx_width(LEN);

  logic [W-1:0]  tab [LEN];
  logic [IW-1:0] pos;
  logic          at_end;

  for (genvar i = 0; i < LEN; i++) begin : g_tab
    assign tab[i] = W'(sp_pkg::ramp_elem(BASE, STEP, i));
  end

  sp_idx_ctr #(.LEN(LEN)) u_pos (
    .clk     (clk),
    .rst     (rst),
    .idx     (pos),
    .at_last (at_end)
  );

  assign data = tab[pos];

  AST_GEN_HOLDS_LAST: assert property (@(posedge clk) disable iff (rst)
    at_end |=> $stable(data));                                      // R2

endmodule

// File: rtl/sp_seq_check.sv
module sp_seq_check #(
  parameter int W     = 8,
  parameter int LEN   = 10,
  parameter int BASE  = 0,
  parameter int STEP  = 1,
  parameter int CYC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     obs,
  input  logic [W-1:0]     thru_in,
  output logic [W-1:0]     thru_out,
  output logic [W-1:0]     expect_val,
  output logic             miscompare,
  output logic [CYC_W-1:0] cycle,
  output logic             err,
  output logic             done
);
  localparam int IW = sp_pkg::idx_width(LEN);
  localparam logic [CYC_W-1:0] CYC_MAX = '1;

  logic [W-1:0]  tab [LEN];
  logic [IW-1:0] pos;
  logic          at_end;

  for (genvar i = 0; i < LEN; i++) begin : g_tab
    assign tab[i] = W'(sp_pkg::ramp_elem(BASE, STEP, i));
  end

  sp_idx_ctr #(.LEN(LEN)) u_pos (
    .clk     (clk),
    .rst     (rst),
    .idx     (pos),
    .at_last (at_end)
  );

  assign expect_val = tab[pos];
  assign miscompare = !rst && (obs != expect_val);
  assign thru_out   = thru_in;

  always_ff @(posedge clk) begin
    if (rst)                  cycle <= '0;
    else if (cycle != CYC_MAX) cycle <= cycle + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             err <= 1'b0;
    else if (miscompare) err <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         done <= 1'b0;
    else if (at_end) done <= 1'b1;
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    at_end |=> done);                                               // R5
  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (rst)
    done |=> done);                                                 // R5
  AST_ERR_ON_MISS: assert property (@(posedge clk) disable iff (rst)
    miscompare |=> err);                                            // R9
  AST_ERR_STAYS: assert property (@(posedge clk) disable iff (rst)
    err |=> err);                                                   // R9
  AST_CYCLE_COUNTS: assert property (@(posedge clk) disable iff (rst)
    (cycle != CYC_MAX) |=> cycle == $past(cycle) + 1'b1);           // R4
  AST_EXPECT_PARKED: assert property (@(posedge clk) disable iff (rst)
    at_end |=> $stable(expect_val));                                // R6

endmodule

// File: rtl/seq_stim_check.sv
module seq_stim_check #(
  parameter int W        = 8,
  parameter int SRC_LEN  = 11,
  parameter int SRC_BASE = 1,
  parameter int SRC_STEP = 2,
  parameter int CHK_LEN  = 10,
  parameter int CHK_BASE = 0,
  parameter int CHK_STEP = 1,
  parameter int CYC_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic [W-1:0]     src_data,
  input  logic [W-1:0]     chk_obs,
  input  logic [W-1:0]     chk_thru_in,
  output logic [W-1:0]     chk_thru_out,
  output logic [W-1:0]     chk_expect,
  output logic             chk_miscompare,
  output logic [CYC_W-1:0] chk_cycle,
  output logic             chk_err,
  output logic             chk_done
);

  sp_stim_gen #(
    .W(W), .LEN(SRC_LEN), .BASE(SRC_BASE), .STEP(SRC_STEP)
  ) u_src (
    .clk  (clk),
    .rst  (rst),
    .data (src_data)
  );

  sp_seq_check #(
    .W(W), .LEN(CHK_LEN), .BASE(CHK_BASE), .STEP(CHK_STEP), .CYC_W(CYC_W)
  ) u_chk (
    .clk        (clk),
    .rst        (rst),
    .obs        (chk_obs),
    .thru_in    (chk_thru_in),
    .thru_out   (chk_thru_out),
    .expect_val (chk_expect),
    .miscompare (chk_miscompare),
    .cycle      (chk_cycle),
    .err        (chk_err),
    .done       (chk_done)
  );

  AST_QUIET_IN_RESET: assert property (@(posedge clk)
    rst |-> !chk_miscompare);                                       // R8

endmodule

// File: tb/tb_seq_stim_check.sv
module tb_seq_stim_check;
  localparam int W = 8, SL = 11, SB = 1, SS = 2, CL = 10, CB = 0, CS = 1, CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] src_data, chk_obs = '0, chk_thru_in = '0, chk_thru_out, chk_expect;
  logic chk_miscompare, chk_err, chk_done;
  logic [CW-1:0] chk_cycle;

  int n_vec = 0, n_bad = 0;
  bit model_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  seq_stim_check dut (
    .clk(clk), .rst(rst), .src_data(src_data), .chk_obs(chk_obs),
    .chk_thru_in(chk_thru_in), .chk_thru_out(chk_thru_out),
    .chk_expect(chk_expect), .chk_miscompare(chk_miscompare),
    .chk_cycle(chk_cycle), .chk_err(chk_err), .chk_done(chk_done)
  );

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int src_ref(input int k);
    int p = (k < SL) ? k : SL - 1;
    return (SB + p * SS) & 8'hFF;
  endfunction

  function automatic int chk_ref(input int k);
    int p = (k < CL) ? k : CL - 1;
    return (CB + p * CS) & 8'hFF;
  endfunction

  // Checks taken while reset is held (R8, R7)
  task automatic reset_phase(input int cycles);
    @(negedge clk);
    rst = 1'b1;
    chk_obs = 8'hAA;
    chk_thru_in = 8'h5C;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
    #1;
    check("R8 src_data in reset", int'(src_data), SB);
    check("R8 chk_cycle in reset", int'(chk_cycle), 0);
    check("R8 chk_done in reset", int'(chk_done), 0);
    check("R8 chk_err in reset", int'(chk_err), 0);
    check("R8 miscompare gated in reset", int'(chk_miscompare), 0);
    check("R7 thru in reset", int'(chk_thru_out), 8'h5C);
    model_err = 0;
  endtask

  // One cycle k after release; inject makes the observed value wrong
  task automatic run_cycle(input int k, input bit inject);
    int e;
    bit miss;
    @(negedge clk);
    rst = 1'b0;
    e = chk_ref(k);
    chk_obs = W'(inject ? (e ^ 8'h55) : e);
    chk_thru_in = W'(k * 7 + 3);
    #1;
    miss = (int'(chk_obs) != e);
    if (k < SL - 1) check("R1 src_data", int'(src_data), src_ref(k));
    else            check("R2 src_data held", int'(src_data), src_ref(k));
    check("R3 chk_expect", int'(chk_expect), e);
    if (k >= CL - 1) check("R6 miscompare past end", int'(chk_miscompare), int'(miss));
    else             check("R3 chk_miscompare", int'(chk_miscompare), int'(miss));
    check("R4 chk_cycle", int'(chk_cycle), k);
    check("R5 chk_done", int'(chk_done), (k >= CL) ? 1 : 0);
    check("R9 chk_err", int'(chk_err), int'(model_err));
    check("R7 chk_thru_out", int'(chk_thru_out), (k * 7 + 3) & 8'hFF);
    check("R10 src index parked", int'(src_data), src_ref(k));
    model_err = model_err | miss;
  endtask

  initial begin
    reset_phase(3);
    for (int k = 0; k < 26; k++)
      run_cycle(k, (k == 3) || (k == 9) || (k == 14) || (k == 21));
    reset_phase(2);
    for (int k = 0; k < 16; k++)
      run_cycle(k, 1'b0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule